// File: doc/BRIEF.md
# Secondary Interrupt Aggregator with Direct Line Routing

This block gathers up to 32 interrupt sources below a primary vectored interrupt controller. Each source level is combined with a software-raised bit for the same source. The result passes through a per-source enable mask, and any enabled, active source asserts a single combined request. That request drives the topmost line of the parent controller.

A window of sources (21 to 30 by default) can also skip the combining stage. When a source in that window has its routing bit set, its level drives the parent line with the same index directly. The same source still feeds the combined request.

Software reaches the block through a simple memory-mapped register bus. The register index is the byte address shifted right by two. Every request line toward the parent is registered.

Top module: `irq_aggregator`

## Requirements
- R1: The register index is the byte address shifted right by two. A read of index 1 returns the effective source level, which is the source inputs ORed with the software bits.
- R2: A read of index 0 returns the effective level ANDed with the enable mask.
- R3: A write to index 2 sets the mask bits written as ones, and a write to index 3 clears the mask bits written as ones. A read of index 2 returns the mask.
- R4: A write to index 4 sets the software bits written as ones, and a write to index 5 clears them. A read of index 4 returns the software bits. Software bits OR into the effective level.
- R5: A write to index 8 sets routing bits, but only bits 21 to 30 can become set (value ANDed with 0x7FE00000). A read of index 8 returns the routing bits.
- R6: A write to index 9 clears the routing bits written as ones.
- R7: Parent line 31 equals the OR of (effective level AND mask), whatever the routing bits hold. It is registered, so it follows a change one clock later.
- R8: For i in 21..30, parent line i equals routing bit i AND effective level bit i, registered one clock later. Parent lines 0..20 stay low.
- R9: A read of any other index returns zero. A write to any other index changes no register.
- R10: Reset clears the mask, the software bits, the routing bits and all parent lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe; read data is zero when low |
| bus_rdata | output | 32 | Combinational read data |
| src_level | input | 32 | Level of each interrupt source |
| parent_irq | output | 32 | Request lines to the parent controller |

## Verification
Read data is combinational, so register reads are checked a moment after the address is driven, in the same cycle. A register write takes effect at the clock edge that samples the strobe. The parent lines follow on the next edge, so an output check after a write waits one more edge. A source level change shows on the parent lines one edge after it is applied. The bench samples just before that edge and expects the old value, then samples after the edge and expects the new one. All stimulus changes on the falling edge and all sampling happens away from the rising edge.

// File: rtl/sic_pkg.sv
package sic_pkg;
  // register word indices
  localparam int unsigned IDX_STATUS  = 0;
  localparam int unsigned IDX_RAW     = 1;
  localparam int unsigned IDX_MSET    = 2;
  localparam int unsigned IDX_MCLR    = 3;
  localparam int unsigned IDX_SWSET   = 4;
  localparam int unsigned IDX_SWCLR   = 5;
  localparam int unsigned IDX_RTSET   = 8;
  localparam int unsigned IDX_RTCLR   = 9;

  typedef enum logic [3:0] {
    OP_NONE, OP_MSET, OP_MCLR, OP_SWSET, OP_SWCLR, OP_RTSET, OP_RTCLR
  } wr_op_e;

  function automatic wr_op_e decode_write(input int unsigned idx);
    case (idx)
      IDX_MSET:  return OP_MSET;
      IDX_MCLR:  return OP_MCLR;
      IDX_SWSET: return OP_SWSET;
      IDX_SWCLR: return OP_SWCLR;
      IDX_RTSET: return OP_RTSET;
      IDX_RTCLR: return OP_RTCLR;
      default:   return OP_NONE;
    endcase
  endfunction
endpackage

// File: rtl/sic_window.sv
// Builds the bit window of sources allowed to route straight to the parent.
module sic_window #(
  parameter int N_SRC   = 32,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  output logic [N_SRC-1:0] win
);
  for (genvar i = 0; i < N_SRC; i++) begin : g_bit
    if (i >= PASS_LO && i <= PASS_HI) begin : g_in
      assign win[i] = 1'b1;
    end else begin : g_out
      assign win[i] = 1'b0;
    end
  end
endmodule

// File: rtl/sic_regs.sv
module sic_regs
  import sic_pkg::*;
#(
  parameter int N_SRC  = 32,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_level,
  input  logic [N_SRC-1:0]  route_win,
  output logic [N_SRC-1:0]  mask_q,
  output logic [N_SRC-1:0]  soft_q,
  output logic [N_SRC-1:0]  route_q,
  output logic [N_SRC-1:0]  level_eff
);
  logic [ADDR_W-1:0] word_idx;
  int unsigned       idx;
  wr_op_e            op;

  assign word_idx  = bus_addr >> 2;
  assign idx       = int'(unsigned'(word_idx));
  assign op        = bus_wr ? decode_write(idx) : OP_NONE;
  assign level_eff = src_level | soft_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q  <= '0;
      soft_q  <= '0;
      route_q <= '0;
    end else begin
      case (op)
        OP_MSET:  mask_q  <= mask_q | bus_wdata;
        OP_MCLR:  mask_q  <= mask_q & ~bus_wdata;
        OP_SWSET: soft_q  <= soft_q | bus_wdata;
        OP_SWCLR: soft_q  <= soft_q & ~bus_wdata;
        OP_RTSET: route_q <= route_q | (bus_wdata & route_win);
        OP_RTCLR: route_q <= route_q & ~bus_wdata;
        default:  ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (idx)
        IDX_STATUS: bus_rdata = level_eff & mask_q;
        IDX_RAW:    bus_rdata = level_eff;
        IDX_MSET:   bus_rdata = mask_q;
        IDX_SWSET:  bus_rdata = soft_q;
        IDX_RTSET:  bus_rdata = route_q;
        default:    bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/sic_route.sv
module sic_route #(
  parameter int N_SRC = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] level_eff,
  input  logic [N_SRC-1:0] mask_q,
  input  logic [N_SRC-1:0] route_q,
  input  logic [N_SRC-1:0] route_win,
  output logic [N_SRC-1:0] parent_irq
);
  localparam int COMB_LINE = N_SRC - 1;

  function automatic logic any_pending(input logic [N_SRC-1:0] lvl,
                                       input logic [N_SRC-1:0] msk);
    return |(lvl & msk);
  endfunction

  for (genvar i = 0; i < N_SRC; i++) begin : g_line
    if (i == COMB_LINE) begin : g_comb
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) parent_irq[i] <= 1'b0;
        else        parent_irq[i] <= any_pending(level_eff, mask_q);
      end
    end else begin : g_pass
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) parent_irq[i] <= 1'b0;
        else        parent_irq[i] <= route_win[i] & route_q[i] & level_eff[i];
      end
    end
  end
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator #(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 12,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [N_SRC-1:0]  bus_wdata,
  input  logic              bus_rd,
  output logic [N_SRC-1:0]  bus_rdata,
  input  logic [N_SRC-1:0]  src_level,
  output logic [N_SRC-1:0]  parent_irq
);
  logic [N_SRC-1:0] route_win;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] soft_q;
  logic [N_SRC-1:0] route_q;
  logic [N_SRC-1:0] level_eff;

  sic_window #(.N_SRC(N_SRC), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)) u_win (
    .win(route_win)
  );

  sic_regs #(.N_SRC(N_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_level(src_level), .route_win(route_win), .mask_q(mask_q),
    .soft_q(soft_q), .route_q(route_q), .level_eff(level_eff)
  );

  sic_route #(.N_SRC(N_SRC)) u_route (
    .clk(clk), .rst_n(rst_n), .level_eff(level_eff), .mask_q(mask_q),
    .route_q(route_q), .route_win(route_win), .parent_irq(parent_irq)
  );
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk #(
  parameter int N_SRC   = 32,
  parameter int ADDR_W  = 12,
  parameter int PASS_LO = 21,
  parameter int PASS_HI = 30
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic [N_SRC-1:0]  bus_wdata,
  input logic              bus_rd,
  input logic [N_SRC-1:0]  bus_rdata,
  input logic [N_SRC-1:0]  parent_irq,
  input logic [N_SRC-1:0]  mask_q,
  input logic [N_SRC-1:0]  route_q,
  input logic [N_SRC-1:0]  level_eff
);
  logic [ADDR_W-1:0] widx;
  logic              known_rd;
  assign widx     = bus_addr >> 2;
  assign known_rd = (widx == 0) || (widx == 1) || (widx == 2) ||
                    (widx == 4) || (widx == 8);

  p_comb_line_r7: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq[N_SRC-1] == $past(|(level_eff & mask_q)));

  p_pass_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq[PASS_HI:PASS_LO] == $past(route_q[PASS_HI:PASS_LO] & level_eff[PASS_HI:PASS_LO]));

  p_low_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    parent_irq[PASS_LO-1:0] == '0);

  p_mask_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 3) |=> ((mask_q & $past(bus_wdata)) == '0));

  p_route_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && widx == 9) |=> ((route_q & $past(bus_wdata)) == '0));

  p_unknown_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !known_rd) |-> (bus_rdata == '0));
endmodule

bind irq_aggregator irq_aggregator_chk #(
  .N_SRC(N_SRC), .ADDR_W(ADDR_W), .PASS_LO(PASS_LO), .PASS_HI(PASS_HI)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .parent_irq(parent_irq), .mask_q(mask_q), .route_q(route_q),
  .level_eff(level_eff)
);

// File: tb/irq_aggregator_tb.sv
module irq_aggregator_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic [31:0] src_level = '0;
  logic [31:0] parent_irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  localparam logic [31:0] WIN = 32'h7FE0_0000;

  always #4 clk = ~clk;

  irq_aggregator u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .src_level(src_level), .parent_irq(parent_irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [11:0] a, input logic [31:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, bus_rdata, exp);
    bus_rd = 1'b0;
  endtask

  task automatic settle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset();
    check("R10 parent after reset", parent_irq, 32'h0);
    rd_check("R10 mask reset", 12'h008, 32'h0);
    rd_check("R10 soft reset", 12'h010, 32'h0);
    rd_check("R10 route reset", 12'h020, 32'h0);
  endtask

  task automatic t_mask();
    src_level = 32'h0000_00A5;
    rd_check("R1 raw level", 12'h004, 32'h0000_00A5);
    rd_check("R2 masked level, empty mask", 12'h000, 32'h0);
    settle();
    check("R7 no request when masked", parent_irq, 32'h0);
    wr(12'h008, 32'h0000_0005);
    rd_check("R3 mask readback", 12'h008, 32'h0000_0005);
    rd_check("R2 masked level", 12'h000, 32'h0000_0005);
    settle();
    check("R7 combined request", parent_irq, 32'h8000_0000);
    wr(12'h00C, 32'h0000_0004);
    rd_check("R3 mask partial clear", 12'h008, 32'h0000_0001);
    wr(12'h00C, 32'h0000_0001);
    settle();
    check("R7 request drops", parent_irq, 32'h0);
  endtask

  task automatic t_soft();
    src_level = '0;
    wr(12'h010, 32'h0000_0100);
    rd_check("R4 soft readback", 12'h010, 32'h0000_0100);
    rd_check("R4 soft in raw level", 12'h004, 32'h0000_0100);
    wr(12'h008, 32'h0000_0100);
    settle();
    check("R4 soft raises request", parent_irq, 32'h8000_0000);
    wr(12'h014, 32'h0000_0100);
    rd_check("R4 soft cleared", 12'h004, 32'h0);
    settle();
    check("R4 request gone after soft clear", parent_irq, 32'h0);
    wr(12'h00C, 32'hFFFF_FFFF);
  endtask

  task automatic t_route();
    wr(12'h020, 32'hFFFF_FFFF);
    rd_check("R5 route set limited to window", 12'h020, WIN);
    src_level = 32'h0200_0008;
    settle();
    check("R8 direct line 25 only", parent_irq, 32'h0200_0000);
    @(negedge clk);
    src_level = 32'h0240_0008;
    #1;
    check("R8 line 22 not before edge", parent_irq, 32'h0200_0000);
    settle();
    check("R8 line 22 after one edge", parent_irq, 32'h0240_0000);
    wr(12'h008, 32'h0200_0000);
    settle();
    check("R7 combined with direct lines", parent_irq, 32'h8240_0000);
    wr(12'h024, 32'h0200_0000);
    rd_check("R6 route clear", 12'h020, WIN & ~32'h0200_0000);
    settle();
    check("R7 combined stays without route", parent_irq, 32'h8040_0000);
  endtask

  task automatic t_unknown();
    wr(12'h018, 32'hFFFF_FFFF);
    wr(12'h400, 32'hFFFF_FFFF);
    wr(12'h408, 32'hFFFF_FFFF);
    rd_check("R9 unknown read", 12'h018, 32'h0);
    rd_check("R9 write-only index reads zero", 12'h00C, 32'h0);
    rd_check("R9 mask untouched", 12'h008, 32'h0200_0000);
    rd_check("R9 soft untouched", 12'h010, 32'h0);
    rd_check("R9 route untouched", 12'h020, WIN & ~32'h0200_0000);
  endtask

  task automatic t_rereset();
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R10 parent cleared in reset", parent_irq, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_mask();
    t_soft();
    t_route();
    t_unknown();
    t_rereset();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule